// File: doc/BRIEF.md
# IO Unit Register Bank with Fault Capture

This block is the register front end of an IO address translation unit. It offers a 32-bit register read/write port over three 4 KB pages. Behind that port sit the translation control word, the page-table base, four per-slot configuration words, two fault logs (one for asynchronous bus write errors, one for memory parity errors) and a module identity word. Only the values that other logic needs leave the block: the translation unit receives the enable, the mapping range, the table base and the slot words, and the bus arbiter receives the arbitration enables. Writes to two write-only strobe locations become single-cycle flush pulses for the translation cache.

The bus side reports errors on single-cycle event inputs. The block also detects slow writes on its own: a counter runs while a write is outstanding and raises a timeout cause once the write has been in flight for 12.8 microseconds, a span set in clock cycles from the clock rate. Each log keeps the first error and its details. Any error that arrives while that first error is still pending only raises a multiple-error flag. Software acknowledges an error by writing the status word.

Top module: `iou_regbank`

## Requirements
- R1: After reset the control word reads IMPL_CODE in bits [31:28] and VERS_CODE in bits [27:24] with zero elsewhere. The asynchronous status reads 0x00800000, the module word reads 0x00000008, and every other readable location reads zero.
- R2: In the control word (byte offset 0x000), bit 0 (enable) and bits [4:2] (range) can be written. They read back and drive cfg_enable and cfg_range from the cycle after the write. All other control bits ignore writes.
- R3: The table base (0x004) and the slot words 0..3 (0x1010, 0x1014, 0x1018, 0x101C) hold all 32 written bits, read them back, and drive cfg_table_base and cfg_slot (slot k in bits [32k+31:32k]).
- R4: A write to 0x014 makes tlb_flush high for exactly the next cycle. A write to 0x018 does the same for page_flush, with the written value on page_flush_data. Both locations read zero.
- R5: Unused locations read zero and ignore writes. The fault address words (0x1004 asynchronous, 0x1024 memory) are read-only.
- R6: Asynchronous status (0x1000): bit 30 is a late error, bit 29 a write timeout and bit 28 an error acknowledge. Bit 31 reads as the OR of bits 30..28, and bits [23:20] always read 0x8. When an event arrives with no cause pending, the block latches every cause present in that cycle, the size into [27:25], supervisor into 24 and read into 18. It also sets bit 17 (address valid) and captures bus_addr at 0x1004.
- R7: An asynchronous event while a cause is pending sets only bit 19. Causes, fields and the address stay unchanged.
- R8: Any write to 0x1000 clears bits 30..28 and 19 and keeps the other fields. If an event arrives in the same cycle as that write, it is logged as a fresh first error with bit 19 clear.
- R9: When bus_wr_busy is high for TMO_CYC consecutive cycles (CLK_MHZ*TIMEOUT_NS/1000), a timeout event occurs with read recorded as 0. A shorter busy period raises nothing, and one busy period raises at most one timeout.
- R10: Memory status (0x1020): a memory event with nonzero mem_perr, when no parity bit is pending, latches the parity bits into [14:13], cpu into 23, boot into 12, cacheable into 11 and the request type into [7:4]. It captures the address at 0x1024. Bit 31 reads as the OR of bits 14:13. An event while parity is pending sets only bit 19, and a write clears [14:13] and 19.
- R11: In the module word (0x2000), bits [20:16] can be written and drive cfg_arb_en. Bits [3:0] always read 0x8 and the other bits read zero.
- R12: reg_rdata takes the addressed value one cycle after reg_rd is sampled high and holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 14 | Byte address within the three pages |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| bus_late_err | input | 1 | Late bus error event |
| bus_err_ack | input | 1 | Error acknowledge on a write event |
| bus_wr_busy | input | 1 | A bus write is outstanding |
| bus_size | input | 3 | Size of the faulting transaction |
| bus_super | input | 1 | Faulting access was in supervisor mode |
| bus_read | input | 1 | Faulting access was a read |
| bus_addr | input | 32 | Faulting bus address |
| mem_err_valid | input | 1 | Memory parity event |
| mem_perr | input | 2 | Parity error on even word (bit 1) and odd word (bit 0) |
| mem_cpu | input | 1 | Processor caused the memory error |
| mem_boot | input | 1 | Error happened in boot mode |
| mem_cache | input | 1 | Address was cacheable |
| mem_rtype | input | 4 | Memory request type |
| mem_addr | input | 32 | Faulting memory address |
| cfg_enable | output | 1 | Translation enable |
| cfg_range | output | 3 | Mapping range code |
| cfg_table_base | output | 32 | Page-table base |
| cfg_slot | output | 128 | Four slot configuration words |
| cfg_arb_en | output | 5 | Arbitration enables |
| tlb_flush | output | 1 | Flush-all pulse |
| page_flush | output | 1 | Single-page flush pulse |
| page_flush_data | output | 32 | Value written with the page flush |

## Verification
A status-register write can land in the same clock cycle as a new fault event. The design must then treat the event as a fresh first error and not as a repeat. The bench provokes this by raising a late error or an error acknowledge in the same cycle as a write to the asynchronous status while an earlier cause is pending. It then reads the status and address back. The causes must equal the new event only, with the multiple-error bit clear and the new address captured. The random phase also interleaves clears with events, and a reference model written from the requirements predicts the status.

// File: rtl/iou_pkg.sv
package iou_pkg;

    localparam int unsigned AW = 14;
    localparam int unsigned DW = 32;
    localparam int unsigned NCAUSE = 3;

    localparam logic [AW-1:0] OFS_CTRL   = 14'h0000;
    localparam logic [AW-1:0] OFS_BASE   = 14'h0004;
    localparam logic [AW-1:0] OFS_TFLUSH = 14'h0014;
    localparam logic [AW-1:0] OFS_PFLUSH = 14'h0018;
    localparam logic [AW-1:0] OFS_AFSR   = 14'h1000;
    localparam logic [AW-1:0] OFS_AFAR   = 14'h1004;
    localparam logic [AW-1:0] OFS_SLOT0  = 14'h1010;
    localparam logic [AW-1:0] OFS_MFSR   = 14'h1020;
    localparam logic [AW-1:0] OFS_MFAR   = 14'h1024;
    localparam logic [AW-1:0] OFS_MODID  = 14'h2000;

    localparam logic [3:0] RESV_NIB = 4'h8;
    localparam logic [3:0] MOD_NIB  = 4'h8;

    typedef struct packed {
        logic late;
        logic tmo;
        logic ack;
    } acause_t;

    typedef struct packed {
        acause_t    cause;
        logic [2:0] size;
        logic       sup;
        logic       multi;
        logic       rd;
        logic       fav;
    } afault_t;

    typedef struct packed {
        logic [1:0] perr;
        logic       cpu;
        logic       multi;
        logic       boot;
        logic       cache;
        logic [3:0] rtype;
    } mfault_t;

    typedef struct packed {
        logic [2:0] range;
        logic       enable;
    } ctrl_t;

    function automatic logic hit(input logic [AW-1:0] a, input logic [AW-1:0] ofs);
        return a[AW-1:2] == ofs[AW-1:2];
    endfunction

    function automatic logic [DW-1:0] afsr_word(input afault_t f);
        return {|f.cause, f.cause, f.size, f.sup, RESV_NIB,
                f.multi, f.rd, f.fav, 17'b0};
    endfunction

    function automatic logic [DW-1:0] mfsr_word(input mfault_t f);
        return {|f.perr, 7'b0, f.cpu, 3'b0, f.multi, 4'b0,
                f.perr, f.boot, f.cache, 3'b0, f.rtype, 4'b0};
    endfunction

endpackage

// File: rtl/iou_wr_timer.sv
module iou_wr_timer #(
    parameter int unsigned LIMIT = 3200
)(
    input  logic clk,
    input  logic rst,
    input  logic busy,
    output logic expired
);
    localparam int unsigned CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!busy) begin
            cnt_q <= '0;
        end else if (cnt_q != CW'(LIMIT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // one-cycle event on the cycle the busy period reaches LIMIT cycles
    assign expired = busy && (cnt_q == CW'(LIMIT - 1));

endmodule

// File: rtl/iou_async_log.sv
module iou_async_log import iou_pkg::*; (
    input  logic          clk,
    input  logic          rst,
    input  acause_t       ev,
    input  logic [2:0]    ev_size,
    input  logic          ev_sup,
    input  logic          ev_rd,
    input  logic [DW-1:0] ev_addr,
    input  logic          clr,
    output afault_t       flt,
    output logic [DW-1:0] flt_addr
);
    afault_t       f_q;
    logic [DW-1:0] a_q;
    logic          any_ev;
    logic          pending;

    assign any_ev  = |ev;
    assign pending = |f_q.cause;

    always_ff @(posedge clk) begin
        if (rst) begin
            f_q <= '0;
            a_q <= '0;
        end else if (any_ev && (!pending || clr)) begin
            f_q.cause <= ev;
            f_q.size  <= ev_size;
            f_q.sup   <= ev_sup;
            f_q.rd    <= ev_rd && !ev.tmo;
            f_q.multi <= 1'b0;
            f_q.fav   <= 1'b1;
            a_q       <= ev_addr;
        end else if (any_ev) begin
            f_q.multi <= 1'b1;
        end else if (clr) begin
            f_q.cause <= '0;
            f_q.multi <= 1'b0;
        end
    end

    assign flt      = f_q;
    assign flt_addr = a_q;

endmodule

// File: rtl/iou_mem_log.sv
module iou_mem_log import iou_pkg::*; (
    input  logic          clk,
    input  logic          rst,
    input  logic          ev_valid,
    input  logic [1:0]    ev_perr,
    input  logic          ev_cpu,
    input  logic          ev_boot,
    input  logic          ev_cache,
    input  logic [3:0]    ev_rtype,
    input  logic [DW-1:0] ev_addr,
    input  logic          clr,
    output mfault_t       flt,
    output logic [DW-1:0] flt_addr
);
    mfault_t       f_q;
    logic [DW-1:0] a_q;
    logic          fire;
    logic          pending;

    assign fire    = ev_valid && (|ev_perr);
    assign pending = |f_q.perr;

    always_ff @(posedge clk) begin
        if (rst) begin
            f_q <= '0;
            a_q <= '0;
        end else if (fire && (!pending || clr)) begin
            f_q.perr  <= ev_perr;
            f_q.cpu   <= ev_cpu;
            f_q.boot  <= ev_boot;
            f_q.cache <= ev_cache;
            f_q.rtype <= ev_rtype;
            f_q.multi <= 1'b0;
            a_q       <= ev_addr;
        end else if (fire) begin
            f_q.multi <= 1'b1;
        end else if (clr) begin
            f_q.perr  <= '0;
            f_q.multi <= 1'b0;
        end
    end

    assign flt      = f_q;
    assign flt_addr = a_q;

endmodule

// File: rtl/iou_regbank.sv
module iou_regbank import iou_pkg::*; #(
    parameter int unsigned NSLOT      = 4,
    parameter int unsigned CLK_MHZ    = 250,
    parameter int unsigned TIMEOUT_NS = 12800,
    parameter logic [3:0]  IMPL_CODE  = 4'h3,
    parameter logic [3:0]  VERS_CODE  = 4'h1
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [AW-1:0]       reg_addr,
    input  logic [DW-1:0]       reg_wdata,
    output logic [DW-1:0]       reg_rdata,
    input  logic                bus_late_err,
    input  logic                bus_err_ack,
    input  logic                bus_wr_busy,
    input  logic [2:0]          bus_size,
    input  logic                bus_super,
    input  logic                bus_read,
    input  logic [DW-1:0]       bus_addr,
    input  logic                mem_err_valid,
    input  logic [1:0]          mem_perr,
    input  logic                mem_cpu,
    input  logic                mem_boot,
    input  logic                mem_cache,
    input  logic [3:0]          mem_rtype,
    input  logic [DW-1:0]       mem_addr,
    output logic                cfg_enable,
    output logic [2:0]          cfg_range,
    output logic [DW-1:0]       cfg_table_base,
    output logic [NSLOT*DW-1:0] cfg_slot,
    output logic [4:0]          cfg_arb_en,
    output logic                tlb_flush,
    output logic                page_flush,
    output logic [DW-1:0]       page_flush_data
);
    localparam int unsigned TMO_CYC = CLK_MHZ * TIMEOUT_NS / 1000;
    localparam int unsigned WA      = AW - 2;
    localparam logic [WA-1:0] SLOT_W0 = OFS_SLOT0[AW-1:2];

    ctrl_t         ctrl_q;
    logic [DW-1:0] base_q;
    logic [4:0]    arb_q;
    logic          tfl_q;
    logic          pfl_q;
    logic [DW-1:0] pfl_data_q;
    logic [DW-1:0] rdata_q;
    logic [DW-1:0] rd_mux;

    logic [NSLOT-1:0][DW-1:0] slot_w;

    acause_t       a_ev;
    afault_t       a_flt;
    logic [DW-1:0] a_addr;
    mfault_t       m_flt;
    logic [DW-1:0] m_addr;
    logic          tmo_ev;
    logic          a_clr;
    logic          m_clr;

    // ---------------- write side ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            base_q <= '0;
            arb_q  <= '0;
        end else if (reg_wr) begin
            if (hit(reg_addr, OFS_CTRL)) begin
                ctrl_q.range  <= reg_wdata[4:2];
                ctrl_q.enable <= reg_wdata[0];
            end
            if (hit(reg_addr, OFS_BASE))  base_q <= reg_wdata;
            if (hit(reg_addr, OFS_MODID)) arb_q  <= reg_wdata[20:16];
        end
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        logic [DW-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (reg_wr && (reg_addr[AW-1:2] == SLOT_W0 + WA'(g))) begin
                q <= reg_wdata;
            end
        end
        assign slot_w[g]             = q;
        assign cfg_slot[g*DW +: DW]  = q;
    end

    // flush strobes: one-cycle pulses after the write
    always_ff @(posedge clk) begin
        if (rst) begin
            tfl_q      <= 1'b0;
            pfl_q      <= 1'b0;
            pfl_data_q <= '0;
        end else begin
            tfl_q <= reg_wr && hit(reg_addr, OFS_TFLUSH);
            pfl_q <= reg_wr && hit(reg_addr, OFS_PFLUSH);
            if (reg_wr && hit(reg_addr, OFS_PFLUSH)) pfl_data_q <= reg_wdata;
        end
    end

    // ---------------- fault logging ----------------
    iou_wr_timer #(.LIMIT(TMO_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .busy    (bus_wr_busy),
        .expired (tmo_ev)
    );

    assign a_ev.late = bus_late_err;
    assign a_ev.tmo  = tmo_ev;
    assign a_ev.ack  = bus_err_ack;
    assign a_clr     = reg_wr && hit(reg_addr, OFS_AFSR);
    assign m_clr     = reg_wr && hit(reg_addr, OFS_MFSR);

    iou_async_log u_alog (
        .clk      (clk),
        .rst      (rst),
        .ev       (a_ev),
        .ev_size  (bus_size),
        .ev_sup   (bus_super),
        .ev_rd    (bus_read),
        .ev_addr  (bus_addr),
        .clr      (a_clr),
        .flt      (a_flt),
        .flt_addr (a_addr)
    );

    iou_mem_log u_mlog (
        .clk      (clk),
        .rst      (rst),
        .ev_valid (mem_err_valid),
        .ev_perr  (mem_perr),
        .ev_cpu   (mem_cpu),
        .ev_boot  (mem_boot),
        .ev_cache (mem_cache),
        .ev_rtype (mem_rtype),
        .ev_addr  (mem_addr),
        .clr      (m_clr),
        .flt      (m_flt),
        .flt_addr (m_addr)
    );

    // ---------------- read side ----------------
    always_comb begin
        rd_mux = '0;
        if (hit(reg_addr, OFS_CTRL))
            rd_mux = {IMPL_CODE, VERS_CODE, 19'b0, ctrl_q.range, 1'b0, ctrl_q.enable};
        if (hit(reg_addr, OFS_BASE))  rd_mux = base_q;
        if (hit(reg_addr, OFS_AFSR))  rd_mux = afsr_word(a_flt);
        if (hit(reg_addr, OFS_AFAR))  rd_mux = a_addr;
        if (hit(reg_addr, OFS_MFSR))  rd_mux = mfsr_word(m_flt);
        if (hit(reg_addr, OFS_MFAR))  rd_mux = m_addr;
        if (hit(reg_addr, OFS_MODID)) rd_mux = {11'b0, arb_q, 12'b0, MOD_NIB};
        for (int i = 0; i < NSLOT; i++) begin
            if (reg_addr[AW-1:2] == SLOT_W0 + WA'(i)) rd_mux = slot_w[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (reg_rd) rdata_q <= rd_mux;
    end

    assign reg_rdata       = rdata_q;
    assign cfg_enable      = ctrl_q.enable;
    assign cfg_range       = ctrl_q.range;
    assign cfg_table_base  = base_q;
    assign cfg_arb_en      = arb_q;
    assign tlb_flush       = tfl_q;
    assign page_flush      = pfl_q;
    assign page_flush_data = pfl_data_q;

endmodule

// File: rtl/iou_regbank_chk.sv
module iou_regbank_chk import iou_pkg::*; (
    input logic          clk,
    input logic          rst,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic [AW-1:0] reg_addr,
    input logic [DW-1:0] reg_rdata,
    input logic [2:0]    cfg_range,
    input logic [4:0]    cfg_arb_en,
    input logic          tlb_flush,
    input logic          page_flush
);
    // R4
    tflush_src_chk: assert property (@(posedge clk) disable iff (rst)
        tlb_flush |-> $past(reg_wr && hit(reg_addr, OFS_TFLUSH)));

    // R4
    pflush_src_chk: assert property (@(posedge clk) disable iff (rst)
        page_flush |-> $past(reg_wr && hit(reg_addr, OFS_PFLUSH)));

    // R6
    afsr_sum_chk: assert property (@(posedge clk) disable iff (rst)
        $past(reg_rd && hit(reg_addr, OFS_AFSR)) |->
            (reg_rdata[31] == (|reg_rdata[30:28])) && (reg_rdata[23:20] == 4'h8));

    // R10
    mfsr_sum_chk: assert property (@(posedge clk) disable iff (rst)
        $past(reg_rd && hit(reg_addr, OFS_MFSR)) |->
            (reg_rdata[31] == (|reg_rdata[14:13])));

    // R11
    modid_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        $past(reg_rd && hit(reg_addr, OFS_MODID)) |->
            (reg_rdata[3:0] == 4'h8) && (reg_rdata[31:21] == 11'b0));

    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(reg_rd) |-> $stable(reg_rdata));

    // R2
    range_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(reg_wr && hit(reg_addr, OFS_CTRL)) |-> $stable(cfg_range));

    // R11
    arb_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(reg_wr && hit(reg_addr, OFS_MODID)) |-> $stable(cfg_arb_en));

endmodule

bind iou_regbank iou_regbank_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .cfg_range  (cfg_range),
    .cfg_arb_en (cfg_arb_en),
    .tlb_flush  (tlb_flush),
    .page_flush (page_flush)
);

// File: tb/test_iou_regbank.sv
module test_iou_regbank;
    import iou_pkg::*;

    localparam int unsigned NSLOT   = 4;
    localparam int unsigned TMO_CYC = 250 * 12800 / 1000;
    localparam logic [31:0] CTRL_RST = 32'h3100_0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_wr = 0, reg_rd = 0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic bus_late_err = 0, bus_err_ack = 0, bus_wr_busy = 0;
    logic [2:0] bus_size = 0;
    logic bus_super = 0, bus_read = 0;
    logic [31:0] bus_addr = 0;
    logic mem_err_valid = 0;
    logic [1:0] mem_perr = 0;
    logic mem_cpu = 0, mem_boot = 0, mem_cache = 0;
    logic [3:0] mem_rtype = 0;
    logic [31:0] mem_addr = 0;
    logic cfg_enable;
    logic [2:0] cfg_range;
    logic [31:0] cfg_table_base;
    logic [NSLOT*32-1:0] cfg_slot;
    logic [4:0] cfg_arb_en;
    logic tlb_flush, page_flush;
    logic [31:0] page_flush_data;

    always #2 clk = ~clk;

    iou_regbank i_iou_regbank (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bus_late_err(bus_late_err), .bus_err_ack(bus_err_ack),
        .bus_wr_busy(bus_wr_busy), .bus_size(bus_size), .bus_super(bus_super),
        .bus_read(bus_read), .bus_addr(bus_addr),
        .mem_err_valid(mem_err_valid), .mem_perr(mem_perr), .mem_cpu(mem_cpu),
        .mem_boot(mem_boot), .mem_cache(mem_cache), .mem_rtype(mem_rtype),
        .mem_addr(mem_addr),
        .cfg_enable(cfg_enable), .cfg_range(cfg_range),
        .cfg_table_base(cfg_table_base), .cfg_slot(cfg_slot),
        .cfg_arb_en(cfg_arb_en), .tlb_flush(tlb_flush),
        .page_flush(page_flush), .page_flush_data(page_flush_data)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // reference model of the fault logs
    logic [2:0]  ma_cause = 0, ma_size = 0;
    logic        ma_sup = 0, ma_multi = 0, ma_rd = 0, ma_fav = 0;
    logic [31:0] ma_addr = 0;
    logic [1:0]  mm_perr = 0;
    logic        mm_cpu = 0, mm_multi = 0, mm_boot = 0, mm_cache = 0;
    logic [3:0]  mm_rtype = 0;
    logic [31:0] mm_addr = 0;

    function automatic logic [31:0] exp_afsr();
        return {|ma_cause, ma_cause, ma_size, ma_sup, 4'h8, ma_multi, ma_rd, ma_fav, 17'b0};
    endfunction

    function automatic logic [31:0] exp_mfsr();
        return {|mm_perr, 7'b0, mm_cpu, 3'b0, mm_multi, 4'b0, mm_perr,
                mm_boot, mm_cache, 3'b0, mm_rtype, 4'b0};
    endfunction

    task automatic model_a(input logic [2:0] c, input logic [2:0] sz, input logic sp,
                           input logic rdb, input logic [31:0] ad, input logic clr);
        if (c != 0 && (ma_cause == 0 || clr)) begin
            ma_cause = c; ma_size = sz; ma_sup = sp; ma_rd = rdb & ~c[1];
            ma_multi = 0; ma_fav = 1; ma_addr = ad;
        end else if (c != 0) begin
            ma_multi = 1;
        end else if (clr) begin
            ma_cause = 0; ma_multi = 0;
        end
    endtask

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1; reg_addr = a;
        @(negedge clk);
        reg_rd = 0;
        d = reg_rdata;
    endtask

    task automatic aev(input logic late, input logic ack, input logic [2:0] sz,
                       input logic sp, input logic rdb, input logic [31:0] ad,
                       input logic clr);
        @(negedge clk);
        bus_late_err = late; bus_err_ack = ack; bus_size = sz;
        bus_super = sp; bus_read = rdb; bus_addr = ad;
        if (clr) begin reg_wr = 1; reg_addr = OFS_AFSR; reg_wdata = $urandom; end
        @(negedge clk);
        bus_late_err = 0; bus_err_ack = 0; reg_wr = 0;
        model_a({late, 1'b0, ack}, sz, sp, rdb, ad, clr);
    endtask

    task automatic mev(input logic [1:0] pe, input logic cp, input logic bt,
                       input logic ch, input logic [3:0] rt, input logic [31:0] ad);
        @(negedge clk);
        mem_err_valid = 1; mem_perr = pe; mem_cpu = cp; mem_boot = bt;
        mem_cache = ch; mem_rtype = rt; mem_addr = ad;
        @(negedge clk);
        mem_err_valid = 0;
        if (pe != 0) begin
            if (mm_perr == 0) begin
                mm_perr = pe; mm_cpu = cp; mm_boot = bt; mm_cache = ch;
                mm_rtype = rt; mm_multi = 0; mm_addr = ad;
            end else mm_multi = 1;
        end
    endtask

    task automatic hold_busy(input int n);
        @(negedge clk);
        bus_wr_busy = 1;
        repeat (n) @(negedge clk);
        bus_wr_busy = 0;
    endtask

    task automatic chk_afsr(input string tag);
        logic [31:0] d;
        rd(OFS_AFSR, d); check({tag, " afsr"}, d, exp_afsr());
        rd(OFS_AFAR, d); check({tag, " afar"}, d, ma_addr);
    endtask

    task automatic chk_mfsr(input string tag);
        logic [31:0] d;
        rd(OFS_MFSR, d); check({tag, " mfsr"}, d, exp_mfsr());
        rd(OFS_MFAR, d); check({tag, " mfar"}, d, mm_addr);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired got 0 exp 1");
        finish_run();
    end

    initial begin
        logic [31:0] d, v;
        int unsigned seed;
        seed = $urandom(32'h5A17_C3E1);
        repeat (4) @(negedge clk);
        rst = 0;

        // R1 reset values
        rd(OFS_CTRL, d);  check("R1 ctrl", d, CTRL_RST);
        rd(OFS_AFSR, d);  check("R1 afsr", d, 32'h0080_0000);
        rd(OFS_MODID, d); check("R1 modid", d, 32'h0000_0008);
        rd(OFS_BASE, d);  check("R1 base", d, 0);
        rd(OFS_MFSR, d);  check("R1 mfsr", d, 0);

        // R2 control
        wr(OFS_CTRL, 32'hFFFF_FFFF);
        check("R2 enable", {31'b0, cfg_enable}, 1);
        check("R2 range", {29'b0, cfg_range}, 7);
        rd(OFS_CTRL, d); check("R2 ctrl read", d, CTRL_RST | 32'h1D);
        wr(OFS_CTRL, 32'h0000_0008);
        rd(OFS_CTRL, d); check("R2 ctrl read2", d, CTRL_RST | 32'h08);

        // R11 module word
        wr(OFS_MODID, 32'hFFFF_FFFF);
        check("R11 arb", {27'b0, cfg_arb_en}, 32'h1F);
        rd(OFS_MODID, d); check("R11 modid read", d, 32'h001F_0008);

        // R4 flush strobes
        @(negedge clk); reg_wr = 1; reg_addr = OFS_TFLUSH; reg_wdata = 32'h1;
        @(negedge clk); reg_wr = 0;
        check("R4 tlb pulse", {31'b0, tlb_flush}, 1);
        @(negedge clk);
        check("R4 tlb pulse end", {31'b0, tlb_flush}, 0);
        @(negedge clk); reg_wr = 1; reg_addr = OFS_PFLUSH; reg_wdata = 32'hFEED_1000;
        @(negedge clk); reg_wr = 0;
        check("R4 page pulse", {31'b0, page_flush}, 1);
        check("R4 page data", page_flush_data, 32'hFEED_1000);
        @(negedge clk);
        check("R4 page pulse end", {31'b0, page_flush}, 0);
        rd(OFS_PFLUSH, d); check("R4 pflush reads 0", d, 0);
        rd(OFS_TFLUSH, d); check("R4 tflush reads 0", d, 0);

        // R5 unused and read-only
        wr(14'h0008, 32'hDEAD_BEEF);
        rd(14'h0008, d); check("R5 unused", d, 0);
        wr(OFS_AFAR, 32'h1234_5678);
        rd(OFS_AFAR, d); check("R5 afar ro", d, 0);
        wr(OFS_MFAR, 32'h1234_5678);
        rd(OFS_MFAR, d); check("R5 mfar ro", d, 0);

        // R6 first error with two simultaneous causes, R7 repeat
        aev(1, 1, 3'd6, 1, 1, 32'hF000_1230, 0);
        chk_afsr("R6 first");
        aev(1, 0, 3'd1, 0, 0, 32'h0BAD_0000, 0);
        chk_afsr("R7 multi");

        // R8 plain clear, then collision of clear and new event
        wr(OFS_AFSR, 32'h0);
        model_a(0, 0, 0, 0, 0, 1);
        chk_afsr("R8 clear");
        aev(1, 0, 3'd2, 0, 1, 32'h1111_0000, 0);
        aev(0, 1, 3'd4, 1, 0, 32'h2222_0000, 1);
        chk_afsr("R8 collision");
        wr(OFS_AFSR, 32'h0); model_a(0, 0, 0, 0, 0, 1);

        // R9 timeout
        bus_size = 3'd5; bus_super = 1; bus_read = 1; bus_addr = 32'hABC0_0000;
        hold_busy(TMO_CYC - 1);
        chk_afsr("R9 short busy");
        hold_busy(TMO_CYC);
        model_a(3'b010, 3'd5, 1, 1, 32'hABC0_0000, 0);
        chk_afsr("R9 timeout");
        wr(OFS_AFSR, 32'h0); model_a(0, 0, 0, 0, 0, 1);
        hold_busy(2 * TMO_CYC + 5);
        model_a(3'b010, 3'd5, 1, 1, 32'hABC0_0000, 0);
        chk_afsr("R9 once per period");
        wr(OFS_AFSR, 32'h0); model_a(0, 0, 0, 0, 0, 1);
        bus_read = 0; bus_super = 0;

        // R10 memory fault
        mev(2'b00, 1, 1, 1, 4'hF, 32'h0000_0040);
        chk_mfsr("R10 zero perr ignored");
        mev(2'b10, 1, 0, 1, 4'hA, 32'h0000_5000);
        chk_mfsr("R10 first");
        mev(2'b01, 0, 1, 0, 4'h3, 32'h0000_6000);
        chk_mfsr("R10 multi");
        wr(OFS_MFSR, 32'h0); mm_perr = 0; mm_multi = 0;
        chk_mfsr("R10 clear");

        // R12 read data holds
        wr(OFS_BASE, 32'hCAFE_0000);
        rd(OFS_BASE, d);
        wr(OFS_BASE, 32'h0000_BEEF);
        repeat (3) @(negedge clk);
        check("R12 hold", reg_rdata, 32'hCAFE_0000);

        // random phase
        for (int it = 0; it < 300; it++) begin
            int op;
            op = $urandom % 5;
            case (op)
                0: begin
                    int k;
                    logic [AW-1:0] a;
                    k = $urandom % (NSLOT + 1);
                    v = $urandom;
                    a = (k == NSLOT) ? OFS_BASE : OFS_SLOT0 + AW'(4 * k);
                    wr(a, v);
                    rd(a, d); check("R3 readback", d, v);
                    if (k == NSLOT) check("R3 cfg base", cfg_table_base, v);
                    else check("R3 cfg slot", cfg_slot[k*32 +: 32], v);
                end
                1: begin
                    logic [1:0] c;
                    c = 2'($urandom % 3) + 2'd1;
                    aev(c[1], c[0], 3'($urandom), 1'($urandom), 1'($urandom),
                        $urandom, 1'(($urandom % 4) == 0));
                    chk_afsr("R6 R7 R8 random");
                end
                2: begin
                    wr(OFS_AFSR, $urandom); model_a(0, 0, 0, 0, 0, 1);
                    chk_afsr("R8 random clear");
                end
                3: begin
                    mev(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                        4'($urandom), $urandom);
                    chk_mfsr("R10 random");
                end
                default: begin
                    wr(OFS_MFSR, $urandom); mm_perr = 0; mm_multi = 0;
                    chk_mfsr("R10 random clear");
                end
            endcase
        end

        finish_run();
    end

endmodule